// File: doc/BRIEF.md
# Indexed Register Bank with Latched Push-Buttons

This block sits beside a small host controller that reaches it through a handful of general-purpose pins: an 8-bit data bus, a select line that picks between index and data, and active-low chip select, write strobe and read strobe. A write with the select line low stores the bus value as an index. Later accesses with the select line high read or write the register that this index names. The host can therefore reach a whole bank of registers through only twelve pins.

The bank has three kinds of register. A button status register shows a 0 for each button whose press has been caught. Each button also has a write-only clear location. An LED register drives active-low LED outputs. Button inputs pass through a two-flop synchronizer. A press edge sets a latch that stays set after the button is released and stays set until the host clears it. Host strobes are sampled in the block's own clock domain. Register updates happen on the rising edge of the write strobe, so each host write causes exactly one update.

Top module: `idx_reg_bank`

## Requirements
- R1: After reset the index is 0, the status register (index 0) reads 0xFF, and `led_n` is 0xFF.
- R2: `bus_oe` is high exactly when `a0`=1, `cs_n`=0 and `rd_n`=0, and `bus_o` then carries the register that the current index selects.
- R3: A write strobe with `a0`=0 and `cs_n`=0 loads the bus value into the index. The index then stays unchanged across any number of data reads and writes.
- R4: A write with `a0`=1 while the index is 7 loads the LED register. `led_n` outputs it directly, and a 0 bit lights an LED. Reading index 7 returns the stored value.
- R5: A write takes effect on the third rising clock edge after `wr_n` rises. A strobe held low for many cycles still gives exactly one update, using the data present in the last low cycle.
- R6: In the status register, bit k (k = 0..5) reads 0 from the third clock edge after button k's synchronized input falls. It keeps reading 0 after the button is released. Bits 6 and 7 always read 1.
- R7: A data write with any value while the index is k+1 (k = 0..5) clears the latch of button k only.
- R8: If a press edge and the clear for the same button land in the same cycle, the latch stays set.
- R9: Data writes to index 0 or to index 8 and above change neither the latches nor the LEDs. Reads of any index other than 0 and 7 return 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| a0 | input | 1 | 0 = index access, 1 = data access |
| bus_i | input | 8 | Data from host |
| bus_o | output | 8 | Data to host |
| bus_oe | output | 1 | Drive enable for `bus_o` |
| btn_n | input | 6 | Raw buttons, low while pressed |
| led_n | output | 8 | LED drive, active low |

## Verification
Reads are combinational from the pins and are sampled one clock after the strobes are asserted. Writes and button presses both pass through three flop stages, so their results are due on the third rising edge after the triggering transition. The bench waits four cycles before sampling. One directed case samples just before and just after that third edge to pin down the latency. The press-versus-clear case lines up both transitions on the same falling edge, so both events reach the latch in the same cycle.

// File: rtl/idx_reg_bank.sv
module idx_reg_bank #(
  parameter int DW      = 8,
  parameter int NBTN    = 6,
  parameter int LED_IDX = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            wr_n,
  input  logic            rd_n,
  input  logic            a0,
  input  logic [DW-1:0]   bus_i,
  output logic [DW-1:0]   bus_o,
  output logic            bus_oe,
  input  logic [NBTN-1:0] btn_n,
  output logic [DW-1:0]   led_n
);
  localparam int HW = DW + 3;
  localparam logic [HW-1:0] HIDLE = {3'b111, {DW{1'b0}}};

  logic [HW-1:0] hp1, hp2, hp3;
  logic [NBTN-1:0] b1, b2, b3, lat, press, clr;
  logic [DW-1:0] idx_q, led_q, stat, rd_val, wd;
  logic wr_evt, wa0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hp1 <= HIDLE;
      hp2 <= HIDLE;
      hp3 <= HIDLE;
      b1  <= '1;
      b2  <= '1;
      b3  <= '1;
    end else begin
      hp1 <= {wr_n, cs_n, a0, bus_i};
      hp2 <= hp1;
      hp3 <= hp2;
      b1  <= btn_n;
      b2  <= b1;
      b3  <= b2;
    end

  assign wr_evt = !hp3[DW+2] && hp2[DW+2] && !hp3[DW+1];
  assign wa0    = hp3[DW];
  assign wd     = hp3[DW-1:0];
  assign press  = b3 & ~b2;

  for (genvar k = 0; k < NBTN; k++) begin : g_clr
    assign clr[k] = wr_evt && wa0 && (idx_q == DW'(k + 1));
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      idx_q <= '0;
      led_q <= '1;
      lat   <= '0;
    end else begin
      if (wr_evt && !wa0) idx_q <= wd;
      if (wr_evt && wa0 && idx_q == DW'(LED_IDX)) led_q <= wd;
      lat <= (lat & ~clr) | press;
    end

  assign stat = ~{{(DW-NBTN){1'b0}}, lat};

  always_comb
    if (idx_q == '0)                rd_val = stat;
    else if (idx_q == DW'(LED_IDX)) rd_val = led_q;
    else                            rd_val = '1;

  assign bus_oe = a0 && !cs_n && !rd_n;
  assign bus_o  = rd_val;
  assign led_n  = led_q;
endmodule

// File: rtl/idx_reg_bank_chk.sv
module idx_reg_bank_chk #(
  parameter int DW      = 8,
  parameter int NBTN    = 6,
  parameter int LED_IDX = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cs_n,
  input logic            rd_n,
  input logic            a0,
  input logic            bus_oe,
  input logic            wr_evt,
  input logic            wa0,
  input logic [DW-1:0]   idx_q,
  input logic [DW-1:0]   led_n,
  input logic [NBTN-1:0] lat,
  input logic [NBTN-1:0] press
);
  // R2
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (a0 && !cs_n && !rd_n));

  // R3
  idx_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(idx_q) |-> ($past(wr_evt) && !$past(wa0)));

  // R4
  led_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(led_n) |-> ($past(wr_evt) && $past(wa0) && $past(idx_q) == DW'(LED_IDX)));

  // R6
  lat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(lat & ~$past(lat))) |-> ((lat & ~$past(lat) & ~$past(press)) == '0));

  // R8
  press_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|$past(press)) |-> ((lat & $past(press)) == $past(press)));
endmodule

bind idx_reg_bank idx_reg_bank_chk #(.DW(DW), .NBTN(NBTN), .LED_IDX(LED_IDX)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .a0(a0), .bus_oe(bus_oe),
  .wr_evt(wr_evt), .wa0(wa0), .idx_q(idx_q), .led_n(led_n), .lat(lat), .press(press)
);

// File: tb/sim_idx_reg_bank.sv
module sim_idx_reg_bank;
  logic clk = 0, rst_n = 0;
  logic cs_n = 1, wr_n = 1, rd_n = 1, a0 = 1;
  logic [7:0] bus_i = 0;
  logic [7:0] bus_o, led_n;
  logic bus_oe;
  logic [5:0] btn_n = '1;
  int runs = 0, fails = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  idx_reg_bank u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .a0(a0), .bus_i(bus_i), .bus_o(bus_o), .bus_oe(bus_oe), .btn_n(btn_n), .led_n(led_n));

  // {write index, write data, read index, expected read}
  localparam logic [31:0] VEC [8] = '{
    32'h07_00_07_00,   // R4 all on
    32'h07_FF_07_FF,   // R4 all off
    32'h07_A5_07_A5,   // R4 pattern
    32'h00_12_07_A5,   // R9 write to status ignored
    32'h03_5A_07_A5,   // R9 write to clear location leaves LEDs
    32'h09_00_07_A5,   // R9 unused index ignored
    32'h07_3C_00_FF,   // R6 status untouched by LED write
    32'h05_00_05_FF    // R9 unused read returns 0xFF
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic sel, input logic [7:0] d);
    @(negedge clk); a0 = sel; cs_n = 0; wr_n = 0; bus_i = d;
    repeat (2) @(negedge clk);
    wr_n = 1;
    @(negedge clk); cs_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_rd(output logic [7:0] d);
    @(negedge clk); a0 = 1; cs_n = 0; rd_n = 0;
    @(negedge clk); d = bus_o;
    chk("R2 oe", {7'd0, bus_oe}, 8'd1);
    rd_n = 1; cs_n = 1;
  endtask

  task automatic reg_wr(input logic [7:0] i, input logic [7:0] d);
    bus_wr(0, i); bus_wr(1, d);
  endtask

  task automatic reg_rd(input logic [7:0] i, output logic [7:0] d);
    bus_wr(0, i); bus_rd(d);
  endtask

  task automatic press(input int k, input logic v);
    @(negedge clk); btn_n[k] = v;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 led", led_n, 8'hFF);
    chk("R2 idle oe", {7'd0, bus_oe}, 8'd0);
    bus_rd(rv); chk("R1 index0 status", rv, 8'hFF);

    foreach (VEC[i]) begin
      reg_wr(VEC[i][31:24], VEC[i][23:16]);
      reg_rd(VEC[i][15:8], rv);
      chk("R4/R9 vector", rv, VEC[i][7:0]);
    end
    chk("R4 led pins", led_n, 8'h3C);

    // R3 index held across data accesses
    bus_wr(0, 8'h07);
    bus_wr(1, 8'h81);
    bus_rd(rv); chk("R3 retain", rv, 8'h81);
    bus_rd(rv); chk("R3 retain again", rv, 8'h81);

    // R2 no drive with a0 low
    @(negedge clk); a0 = 0; cs_n = 0; rd_n = 0;
    @(negedge clk); chk("R2 a0 low", {7'd0, bus_oe}, 8'd0);
    rd_n = 1; cs_n = 1; a0 = 1;

    // R5 latency and single update on a long strobe
    @(negedge clk); a0 = 1; cs_n = 0; wr_n = 0; bus_i = 8'h11;
    repeat (6) @(negedge clk);
    bus_i = 8'h66;
    @(negedge clk); wr_n = 1;
    @(negedge clk); cs_n = 1;
    @(negedge clk); chk("R5 before third edge", led_n, 8'h81);
    @(negedge clk); chk("R5 third edge", led_n, 8'h66);

    // R6 latch and R7 clear
    press(0, 0); press(0, 1);
    reg_rd(0, rv); chk("R6 S1 latched", rv, 8'hFE);
    press(3, 0); press(3, 1);
    reg_rd(0, rv); chk("R6 bit3 latched", rv, 8'hF6);
    reg_wr(2, 8'h00);
    reg_rd(0, rv); chk("R7 wrong clear", rv, 8'hF6);
    reg_wr(1, 8'h5A);
    reg_rd(0, rv); chk("R7 clear bit0", rv, 8'hF7);
    reg_wr(4, 8'hFF);
    reg_rd(0, rv); chk("R7 clear bit3", rv, 8'hFF);
    press(5, 0);
    reg_rd(0, rv); chk("R6 bit5 held", rv, 8'hDF);
    press(5, 1);
    reg_wr(0, 8'h00);
    reg_rd(0, rv); chk("R9 status write ignored", rv, 8'hDF);
    reg_wr(6, 8'h00);
    reg_rd(0, rv); chk("R7 clear bit5", rv, 8'hFF);

    // R8 press and clear in the same cycle
    bus_wr(0, 8'h01);
    @(negedge clk); a0 = 1; cs_n = 0; wr_n = 0;
    repeat (2) @(negedge clk);
    wr_n = 1; btn_n[0] = 0;
    @(negedge clk); cs_n = 1;
    repeat (4) @(negedge clk);
    btn_n[0] = 1;
    reg_rd(0, rv); chk("R8 press wins", rv, 8'hFE);

    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule